// File: doc/BRIEF.md
# Paired PWM Clock Source Generator

This block builds the common time base for two neighbouring PWM channels. It picks one of two reference tick streams, passes or blocks it with a gate bit, and divides it by a power of two, from 1 up to 256. Every clock in the block is the single system clock `clk`. The reference inputs are one-cycle tick strobes in that domain, so the divided result is also a one-cycle strobe, `pairTick`. A toggle register turns that strobe into a 50 percent duty level, `pairClk`.

Each of the two channels gets its own bypass clock: `pairClk` gated by that channel's enable bit. When a channel's bypass bit is set, its output pin carries this bypass clock in place of the PWM waveform supplied from the channel logic. Duty and polarity then have no effect on the pin. All configuration comes from one 8-bit per-pair control word and a two-bit channel enable vector.

Top module: `pairclk_gen`

## Requirements
- R1: While reset is low and right after it, `pairTick`, `pairClk` and `bypClk` are 0, and with both bypass bits clear `chanOut` equals `pwmIn`.
- R2: Control bit 7 selects the source: 0 counts ticks on `refTickA` only, 1 counts ticks on `refTickB` only. Ticks on the other input have no effect on `pairTick`.
- R3: Control bit 4 is the gate. While it is 0, no ticks are counted, `pairTick` and `pairClk` are 0 from the next cycle on, and the divider count restarts from zero.
- R4: Control bits 3:0 hold an exponent m. `pairTick` is high for one cycle, in the cycle after the 2^m-th counted tick since the last restart, and again after every further 2^m counted ticks.
- R5: An exponent value above 8 divides by 256, the same as 8.
- R6: `pairClk` changes value exactly in the cycles where `pairTick` is high. It restarts at 0, so it is a 50 percent clock whose period is twice the division ratio.
- R7: A change of the effective exponent restarts the divider. A tick arriving in the same cycle as the change is dropped, `pairTick` stays low, `pairClk` returns to 0, and the next pulse needs a full 2^m new ticks.
- R8: `bypClk[i]` is high only while both `pairClk` and `chanEn[i]` are high.
- R9: Control bit 5 puts channel 0 into bypass and bit 6 does the same for channel 1. In bypass, `chanOut[i]` follows `bypClk[i]` and `pwmIn[i]` is ignored. Otherwise `chanOut[i]` follows `pwmIn[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 8 | Per-pair control: exponent [3:0], gate [4], bypass ch0 [5], bypass ch1 [6], source select [7] |
| refTickA | input | 1 | Tick strobe of reference source 0 |
| refTickB | input | 1 | Tick strobe of reference source 1 |
| chanEn | input | 2 | Per-channel enable, also used as bypass gate |
| pwmIn | input | 2 | PWM waveform from each channel's duty logic |
| pairTick | output | 1 | Divided strobe, one cycle per 2^m counted ticks |
| pairClk | output | 1 | 50 percent level toggled by each divided strobe |
| bypClk | output | 2 | Per-channel gated copy of `pairClk` |
| chanOut | output | 2 | Channel pin: bypass clock or PWM waveform |

## Verification
Two functions can act in the same cycle: the terminal tick of a count and an exponent change, or the terminal tick and the gate closing. Both cases are provoked by writing the new control word in the same cycle that raises the selected tick. The bench first runs seven ticks at divide-by-4, so the counter sits one tick short of a pulse and `pairClk` is high. The expected result is that the restart wins. No pulse follows, `pairClk` drops to 0, and exactly 2^m further ticks are needed before the next pulse. A checker also asserts that a change of the effective exponent is never followed by a pulse in the next cycle.

// File: rtl/pairclk_pkg.sv
package pairclk_pkg;
  // control word layout; the field positions are decoded by this block
  localparam int CTRL_W   = 8;
  localparam int EXP_LSB  = 0;
  localparam int EXP_W    = 4;
  localparam int GATE_BIT = 4;
  localparam int BYP_LSB  = 5;
  localparam int SRC_BIT  = 7;
  localparam int NUM_CH   = 2;

  // strobes passed from control to datapath
  typedef struct packed {
    logic             tick;   // a selected, gated reference tick
    logic             clear;  // restart the divider this cycle
    logic [EXP_W-1:0] expo;   // clamped divider exponent
  } divStrobe_t;
endpackage

// File: rtl/pairclk_ctl.sv
module pairclk_ctl
  import pairclk_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              refTickA,
  input  logic              refTickB,
  output divStrobe_t        strobe,
  output logic [NUM_CH-1:0] bypSel
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0] rawExp;
  logic [EXP_W-1:0] effExp;
  logic [EXP_W-1:0] prevExp;
  logic             gateOn;
  logic             selTick;

  always_comb begin
    rawExp  = ctrlWord[EXP_LSB +: EXP_W];
    effExp  = (rawExp > EXP_CAP) ? EXP_CAP : rawExp;
    gateOn  = ctrlWord[GATE_BIT];
    selTick = ctrlWord[SRC_BIT] ? refTickB : refTickA;
    strobe.tick  = gateOn & selTick;
    strobe.clear = ~gateOn | (effExp != prevExp);
    strobe.expo  = effExp;
  end

  // remember the exponent in use so that a change can restart the count
  always_ff @(posedge clk) begin
    if (!rstN) prevExp <= '0;
    else       prevExp <= effExp;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bypSel
    assign bypSel[ch] = ctrlWord[BYP_LSB + ch];
  end
endmodule

// File: rtl/pairclk_dp.sv
module pairclk_dp
  import pairclk_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic [NUM_CH-1:0] bypSel,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] pwmIn,
  output logic              pairTick,
  output logic              pairClk,
  output logic [NUM_CH-1:0] bypClk,
  output logic [NUM_CH-1:0] chanOut
);
  localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             hit;

  always_comb begin
    // 2^m - 1 as a mask of m low ones
    lastCnt = ~({CNT_W{1'b1}} << strobe.expo);
    hit     = strobe.tick && (divCnt == lastCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      pairTick <= 1'b0;
      pairClk  <= 1'b0;
    end else if (strobe.clear) begin
      divCnt   <= '0;
      pairTick <= 1'b0;
      pairClk  <= 1'b0;
    end else begin
      pairTick <= hit;
      if (strobe.tick) divCnt <= hit ? '0 : divCnt + 1'b1;
      if (hit) pairClk <= ~pairClk;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign bypClk[ch]  = pairClk & chanEn[ch];
    assign chanOut[ch] = bypSel[ch] ? bypClk[ch] : pwmIn[ch];
  end
endmodule

// File: rtl/pairclk_gen.sv
module pairclk_gen
  import pairclk_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  ctrlWord,
  input  logic        refTickA,
  input  logic        refTickB,
  input  logic [1:0]  chanEn,
  input  logic [1:0]  pwmIn,
  output logic        pairTick,
  output logic        pairClk,
  output logic [1:0]  bypClk,
  output logic [1:0]  chanOut
);
  divStrobe_t        strobe;
  logic [NUM_CH-1:0] bypSel;

  pairclk_ctl #(.MAX_EXP(MAX_EXP)) ctl_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .refTickA(refTickA), .refTickB(refTickB),
    .strobe(strobe), .bypSel(bypSel)
  );

  pairclk_dp #(.MAX_EXP(MAX_EXP)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bypSel(bypSel),
    .chanEn(chanEn), .pwmIn(pwmIn),
    .pairTick(pairTick), .pairClk(pairClk),
    .bypClk(bypClk), .chanOut(chanOut)
  );
endmodule

// File: rtl/pairclk_gen_chk.sv
module pairclk_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlWord,
  input logic       refTickA,
  input logic       refTickB,
  input logic [1:0] chanEn,
  input logic [1:0] pwmIn,
  input logic       pairTick,
  input logic       pairClk,
  input logic [1:0] bypClk,
  input logic [1:0] chanOut
);
  logic       srcTick;
  logic [3:0] effExp;

  always_comb begin
    srcTick = ctrlWord[4] && (ctrlWord[7] ? refTickB : refTickA);
    effExp  = (ctrlWord[3:0] > 4'd8) ? 4'd8 : ctrlWord[3:0];
  end

  // R2: a pulse needs a selected, gated tick one cycle earlier
  assert_tick_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    pairTick |-> $past(srcTick));

  // R3: closed gate clears strobe and level
  assert_gate_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[4] |=> (!pairTick && !pairClk));

  // R6: the level moves together with every pulse
  assert_level_toggles_R6: assert property (@(posedge clk) disable iff (!rstN)
    pairTick |-> (pairClk != $past(pairClk)));

  // R7: an exponent change is never followed by a pulse
  assert_restart_no_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (effExp != $past(effExp)) |=> !pairTick);

  // R8: bypass clock only with enable and level high
  assert_byp_gate_ch0_R8: assert property (@(posedge clk) disable iff (!rstN)
    bypClk[0] |-> (chanEn[0] && pairClk));
  assert_byp_gate_ch1_R8: assert property (@(posedge clk) disable iff (!rstN)
    bypClk[1] |-> (chanEn[1] && pairClk));

  // R9: pin source per bypass bit
  assert_pin_byp_ch0_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[5] |-> (chanOut[0] == (pairClk & chanEn[0])));
  assert_pin_pwm_ch1_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[6] |-> (chanOut[1] == pwmIn[1]));
endmodule

bind pairclk_gen pairclk_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
  .refTickA(refTickA), .refTickB(refTickB),
  .chanEn(chanEn), .pwmIn(pwmIn),
  .pairTick(pairTick), .pairClk(pairClk),
  .bypClk(bypClk), .chanOut(chanOut)
);

// File: tb/pairclk_gen_tb_top.sv
module pairclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {ctrl[7:0], ticks on A[9:0], ticks on B[9:0], expected pulses[7:0]}
  localparam logic [35:0] VEC [0:NVEC-1] = '{
    {8'h10, 10'd5,   10'd3,   8'd5},  // R2 source A, m=0
    {8'h90, 10'd5,   10'd3,   8'd3},  // R2 source B, m=0
    {8'h12, 10'd12,  10'd0,   8'd3},  // R4 m=2
    {8'h92, 10'd8,   10'd7,   8'd1},  // R2 R4 source B, m=2
    {8'h02, 10'd8,   10'd0,   8'd0},  // R3 gate closed
    {8'h13, 10'd20,  10'd0,   8'd2},  // R4 m=3
    {8'h18, 10'd256, 10'd0,   8'd1},  // R4 m=8
    {8'h18, 10'd255, 10'd0,   8'd0},  // R4 m=8 one short
    {8'h1F, 10'd300, 10'd0,   8'd1},  // R5 m=15 acts as 8
    {8'h19, 10'd255, 10'd0,   8'd0},  // R5 m=9 one short of 256
    {8'h9B, 10'd0,   10'd256, 8'd1}   // R5 m=11 on source B
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ctrlWord = 8'h00;
  logic       refTickA = 1'b0;
  logic       refTickB = 1'b0;
  logic [1:0] chanEn = 2'b11;
  logic [1:0] pwmIn = 2'b10;
  logic       pairTick;
  logic       pairClk;
  logic [1:0] bypClk;
  logic [1:0] chanOut;

  int nChecks = 0;
  int nFail = 0;
  int tickCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pairclk_gen dut_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .refTickA(refTickA), .refTickB(refTickB),
    .chanEn(chanEn), .pwmIn(pwmIn),
    .pairTick(pairTick), .pairClk(pairClk),
    .bypClk(bypClk), .chanOut(chanOut)
  );

  always @(negedge clk) if (rstN && pairTick) tickCnt++;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit useB);
    @(negedge clk);
    if (useB) refTickB = 1'b1; else refTickA = 1'b1;
    @(negedge clk);
    refTickA = 1'b0;
    refTickB = 1'b0;
  endtask

  // close the gate briefly, then apply the word: count starts from zero
  task automatic restart(input logic [7:0] w);
    @(negedge clk); ctrlWord = w & 8'hEF;
    idle(1);
    @(negedge clk); ctrlWord = w;
    idle(1);
  endtask

  initial begin
    int base;
    idle(3);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 pairTick after reset", pairTick, 0);
    chk("R1 pairClk after reset", pairClk, 0);
    chk("R1 bypClk after reset", bypClk, 0);
    chk("R1 chanOut follows pwmIn", chanOut, 2'b10);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] w;
      int nA, nB, expN;
      w = VEC[v][35:28]; nA = VEC[v][27:18]; nB = VEC[v][17:8]; expN = VEC[v][7:0];
      restart(w);
      base = tickCnt;
      for (int i = 0; i < nA; i++) pulse(1'b0);
      for (int i = 0; i < nB; i++) pulse(1'b1);
      idle(3);
      chk($sformatf("R4 vector %0d pulse count (R2 R3 R5)", v), tickCnt - base, expN);
      chk($sformatf("R6 vector %0d level parity", v), pairClk, expN % 2);
    end

    // R4 exact pulse timing at m=1
    restart(8'h11);
    @(negedge clk); refTickA = 1'b1;
    @(negedge clk); chk("R4 no pulse after first tick", pairTick, 0);
    @(negedge clk); refTickA = 1'b0;
    chk("R4 pulse after second tick", pairTick, 1);
    chk("R6 level high after first pulse", pairClk, 1);
    @(negedge clk); chk("R4 pulse lasts one cycle", pairTick, 0);

    // R3 gate closing on a tick drops the partial count
    restart(8'h11);
    pulse(1'b0);
    @(negedge clk); ctrlWord = 8'h01; refTickA = 1'b1;
    @(negedge clk); refTickA = 1'b0;
    base = tickCnt;
    for (int i = 0; i < 3; i++) pulse(1'b0);
    idle(2);
    chk("R3 ticks ignored while gated", tickCnt - base, 0);
    chk("R3 level low while gated", pairClk, 0);
    @(negedge clk); ctrlWord = 8'h11;
    pulse(1'b0); idle(2);
    chk("R3 count restarted after gate", tickCnt - base, 0);
    pulse(1'b0); idle(2);
    chk("R3 pulse after full count", tickCnt - base, 1);

    // R7 exponent change collides with the terminal tick
    restart(8'h12);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    idle(2);
    chk("R7 level high before collision", pairClk, 1);
    @(negedge clk); refTickA = 1'b1; ctrlWord = 8'h13;
    @(negedge clk); refTickA = 1'b0;
    chk("R7 no pulse on collision", pairTick, 0);
    chk("R7 level restarts low", pairClk, 0);
    base = tickCnt;
    for (int i = 0; i < 7; i++) pulse(1'b0);
    idle(3);
    chk("R7 no pulse before full new count", tickCnt - base, 0);
    pulse(1'b0); idle(3);
    chk("R7 pulse after eight new ticks", tickCnt - base, 1);

    // R8 R9 bypass gating and pin source
    restart(8'h10);
    chanEn = 2'b01; pwmIn = 2'b00;
    pulse(1'b0); idle(2);
    chk("R8 bypClk gated by chanEn", bypClk, 2'b01);
    @(negedge clk); ctrlWord = 8'h30;
    @(negedge clk); chk("R9 ch0 bypass pin", chanOut, 2'b01);
    pwmIn = 2'b11;
    @(negedge clk); chk("R9 ch1 follows pwmIn", chanOut, 2'b11);
    ctrlWord = 8'h50;
    @(negedge clk); chk("R9 ch1 bypass ignores pwmIn", chanOut, 2'b01);
    chanEn = 2'b11;
    @(negedge clk); chk("R8 both enables", bypClk, 2'b11);
    pwmIn = 2'b00;
    @(negedge clk); chk("R9 mixed pin sources", chanOut, 2'b10);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule